// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block samples a parameterised set of general-purpose input pins, detects the edges that each pin is configured to report, and latches them as interrupt status. Pins are grouped into banks of 32. Each bank has two priority sets, N0 and N1, that work independently of each other. Each set holds its own enable mask and status vector. Software can force status bits on and force them off through write-1 registers. The block drives one interrupt line per bank per set.

Every pin has a small configuration word with a 2-bit edge mode and an input-enable bit. The block treats a change of the input-enable bit while the pin is high as an edge in its own right. Every qualifying event goes to both priority sets of the pin's bank. Each set latches the event only if that set enables the pin at the moment the event occurs. Software programs the block through a simple single-cycle write port and a combinational read port.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: The edge mode field of a pin encodes 0 = no events, 1 = falling edges only, 2 = rising edges only, 3 = both edges.
- R2: A transition on a pin produces an event only while that pin's input-enable bit is 1.
- R3: Writing a pin's input-enable bit from 0 to 1 while the synchronized pin is high is a rising edge, and writing it from 1 to 0 while the pin is high is a falling edge. Either one is qualified by the edge mode written in the same access.
- R4: Every qualifying event is offered to both the N0 and the N1 set of the pin's bank. A set latches its status bit only if its own enable bit for that pin was 1 in the cycle of the event.
- R5: Pin p belongs to bank p/32 at bit position p%32.
- R6: A 1 written to a bit of a clear register resets that status bit, and a 1 written to a set register forces it. Zero bits leave status unchanged in both registers.
- R7: A write to a status address has no effect on the status.
- R8: Each interrupt line is a register holding the OR over its bank of (enable AND status). It therefore changes one clock after the status or enable change that causes it.
- R9: When a hardware event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: After reset, all configuration, enable and status registers read 0 and every interrupt line is low.
- R11: Register map (10-bit address). When addr[9:8]=0, addr[7:0] selects a pin configuration word: bits[1:0] hold the edge mode, bit 4 holds input-enable, and all other bits read 0. When addr[9:8]=1, addr[7:3] is the bank, addr[2] selects the set (0 = N0, 1 = N1), and addr[1:0] selects the register: 0 = enable, 1 = status, 2 = clear, 3 = set. Clear and set read as 0.
- R12: Pin inputs pass through a two-flop synchronizer. An edge is the synchronized value differing from its value one cycle earlier, so a status bit latches on the third rising clock after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_n0_o | output | NUM_PINS/32 | N0 interrupt line, one per bank |
| irq_n1_o | output | NUM_PINS/32 | N1 interrupt line, one per bank |

## Verification
A pin edge detected by the synchronizer can land on the same status bit in the same cycle as a software write-1-to-clear. The bench first forces the bit on with a set write. It then raises the pin on a falling clock edge, waits exactly two rising edges for the synchronized edge to appear, and presents the clear write in that cycle. The bit must still read 1 afterwards. As a control, the same clear with no edge present must read 0.

// File: rtl/gpio_eia_pkg.sv
package gpio_eia_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    // Address regions (addr[9:8])
    localparam logic [1:0] REGION_CFG = 2'd0;
    localparam logic [1:0] REGION_IRQ = 2'd1;

    // Interrupt register kinds (addr[1:0] inside REGION_IRQ)
    localparam logic [1:0] KIND_EN   = 2'd0;
    localparam logic [1:0] KIND_STAT = 2'd1;
    localparam logic [1:0] KIND_CLR  = 2'd2;
    localparam logic [1:0] KIND_SET  = 2'd3;

    // Configuration word field positions
    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_IEN_BIT  = 4;

    // Edge mode: bit0 reports falling edges, bit1 reports rising edges
    function automatic logic edge_hit(logic [1:0] mode, logic rise, logic fall);
        return (rise && mode[1]) || (fall && mode[0]);
    endfunction

endpackage

// File: rtl/gpio_eia_sync.sv
module gpio_eia_sync #(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] prev_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] lvl;
        logic [NUM_PINS-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_i;
        s_d.lvl  = s_q.meta;
        s_d.prev = s_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o  = s_q.lvl;
    assign prev_o = s_q.prev;

    // R12: the delayed copy follows the synchronized level by one cycle
    p_prev_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(lvl_o)));

endmodule

// File: rtl/gpio_eia_pincfg.sv
module gpio_eia_pincfg
    import gpio_eia_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int IDX_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] prev_i,
    output logic [NUM_PINS-1:0] evt_o,
    output logic [DATA_W-1:0]   cfg_rdata
);

    typedef struct packed {
        logic [NUM_PINS-1:0][1:0] mode;
        logic [NUM_PINS-1:0]      ien;
    } cfg_t;

    cfg_t c_d, c_q;
    logic [NUM_PINS-1:0] evt;

    always_comb begin
        c_d = c_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_we && cfg_idx == IDX_W'(i)) begin
                c_d.mode[i] = cfg_wdata[CFG_MODE_LSB +: 2];
                c_d.ien[i]  = cfg_wdata[CFG_IEN_BIT];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            logic pin_rise, pin_fall, en_rise, en_fall;
            pin_rise = c_q.ien[i] & lvl_i[i] & ~prev_i[i];
            pin_fall = c_q.ien[i] & ~lvl_i[i] & prev_i[i];
            en_rise  = c_d.ien[i] & ~c_q.ien[i] & lvl_i[i];
            en_fall  = ~c_d.ien[i] & c_q.ien[i] & lvl_i[i];
            evt[i]   = edge_hit(c_q.mode[i], pin_rise, pin_fall)
                     | edge_hit(c_d.mode[i], en_rise, en_fall);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                cfg_rdata[CFG_MODE_LSB +: 2] = c_q.mode[i];
                cfg_rdata[CFG_IEN_BIT]       = c_q.ien[i];
            end
        end
    end

    assign evt_o = evt;

    // Pins whose mode is 0 before and after this cycle
    logic [NUM_PINS-1:0] mode_off;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++)
            mode_off[i] = (c_q.mode[i] == 2'd0) && (c_d.mode[i] == 2'd0);
    end

    // R2: no event from a pin whose input-enable is low now and stays low
    p_evt_needs_ien_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~c_q.ien & ~c_d.ien) == '0);

    // R1: mode 0 produces no events
    p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & mode_off) == '0);

endmodule

// File: rtl/gpio_eia_bank.sv
module gpio_eia_bank
    import gpio_eia_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] hw_evt,
    input  logic              en_we,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] en_o,
    output logic [BANK_W-1:0] stat_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] stat;
        logic              irq;
    } bank_t;

    bank_t b_d, b_q;
    logic [BANK_W-1:0] set_m, clr_m, hit;

    always_comb begin
        b_d    = b_q;
        set_m  = set_we ? wdata : '0;
        clr_m  = clr_we ? wdata : '0;
        hit    = hw_evt & b_q.en;
        if (en_we) b_d.en = wdata;
        b_d.stat = (b_q.stat & ~clr_m) | set_m | hit;
        b_d.irq  = |(b_q.en & b_q.stat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign en_o   = b_q.en;
    assign stat_o = b_q.stat;
    assign irq_o  = b_q.irq;

    // R6: cleared bits with no competing set or event read 0 next cycle
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat_o & $past(wdata & ~(hw_evt & en_o))) == '0));

    // R6: set bits read 1 next cycle
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((stat_o & $past(wdata)) == $past(wdata)));

    // R9/R4: an enabled event always latches, even against a clear
    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(hw_evt & en_o)) == $past(hw_evt & en_o)));

    // R7: status rises only through a set write or an enabled event
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && ((hw_evt & en_o) == '0)) |=> ((stat_o & ~$past(stat_o)) == '0));

    // R8: interrupt high only if an enabled status bit was pending a cycle earlier
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past((en_o & stat_o) != '0));

endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
    import gpio_eia_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int BANK_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PINS-1:0]          pin_i,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_PINS/BANK_W-1:0]   irq_n0_o,
    output logic [NUM_PINS/BANK_W-1:0]   irq_n1_o
);

    localparam int NUM_BANKS = NUM_PINS / BANK_W;
    localparam int NUM_SETS  = 2;
    localparam int IDX_W     = 8;
    localparam int BANK_SEL_W = 5;

    logic [NUM_PINS-1:0] lvl, prev, evt;
    logic [DATA_W-1:0]   cfg_rdata;
    logic                cfg_we;

    assign cfg_we = wr_en && (wr_addr[9:8] == REGION_CFG);

    gpio_eia_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    gpio_eia_pincfg #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (wr_addr[IDX_W-1:0]),
        .cfg_wdata (wr_data),
        .rd_idx    (rd_addr[IDX_W-1:0]),
        .lvl_i     (lvl),
        .prev_i    (prev),
        .evt_o     (evt),
        .cfg_rdata (cfg_rdata)
    );

    logic [NUM_SETS-1:0][NUM_BANKS-1:0]             irq_w;
    logic [NUM_SETS-1:0][NUM_BANKS-1:0][BANK_W-1:0] en_w, stat_w;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel = wr_en && (wr_addr[9:8] == REGION_IRQ)
                      && (wr_addr[7:3] == BANK_SEL_W'(b))
                      && (wr_addr[2] == 1'(s));

            gpio_eia_bank #(.BANK_W(BANK_W)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .hw_evt (evt[b*BANK_W +: BANK_W]),
                .en_we  (sel && wr_addr[1:0] == KIND_EN),
                .set_we (sel && wr_addr[1:0] == KIND_SET),
                .clr_we (sel && wr_addr[1:0] == KIND_CLR),
                .wdata  (wr_data[BANK_W-1:0]),
                .en_o   (en_w[s][b]),
                .stat_o (stat_w[s][b]),
                .irq_o  (irq_w[s][b])
            );
        end
    end

    assign irq_n0_o = irq_w[0];
    assign irq_n1_o = irq_w[1];

    always_comb begin
        rd_data = '0;
        if (rd_addr[9:8] == REGION_CFG) begin
            rd_data = cfg_rdata;
        end else if (rd_addr[9:8] == REGION_IRQ) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (rd_addr[7:3] == BANK_SEL_W'(b) && rd_addr[2] == 1'(s)) begin
                        if (rd_addr[1:0] == KIND_EN)
                            rd_data[BANK_W-1:0] = en_w[s][b];
                        else if (rd_addr[1:0] == KIND_STAT)
                            rd_data[BANK_W-1:0] = stat_w[s][b];
                    end
                end
            end
        end
    end

    // R4: both sets of a bank see the same events; with equal enables they latch alike
    p_sets_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 1'b0 && en_w[0][0] == en_w[1][0] && stat_w[0][0] == stat_w[1][0])
        |=> (stat_w[0][0] == stat_w[1][0]));

endmodule

// File: tb/sim_gpio_edge_irq_agg.sv
module sim_gpio_edge_irq_agg;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic          wr_en = 1'b0;
    logic [9:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [9:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NB-1:0] irq_n0_o, irq_n1_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq_agg #(.NUM_PINS(NP), .BANK_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_n0_o(irq_n0_o), .irq_n1_o(irq_n1_o)
    );

    function automatic logic [9:0] a_irq(int bank, int set, int kind);
        return 10'h100 | 10'(bank << 3) | 10'(set << 2) | 10'(kind);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < 2; s++)
                wr(a_irq(b, s, 2), 32'hFFFF_FFFF);
    endtask

    // mode, ien, en0, en1, v0, v1, exp0, exp1
    typedef struct packed {
        logic [1:0] mode;
        logic ien, en0, en1, v0, v1, e0, e1;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10: reset state
        rd(a_irq(0, 0, 1), d); chk("R10 status N0 b0", d, 0);
        rd(a_irq(1, 1, 1), d); chk("R10 status N1 b1", d, 0);
        rd(a_irq(0, 1, 0), d); chk("R10 enable N1 b0", d, 0);
        rd(10'd5, d);          chk("R10 cfg pin5", d, 0);
        chk("R10 irq lines", {30'd0, irq_n1_o[0], irq_n0_o[0]}, 0);

        // R1/R2/R4: table of pin-edge vectors on pin 5
        foreach (VECS[k]) begin
            vec_t v;
            v = VECS[k];
            wr(a_irq(0, 0, 0), 0);
            wr(a_irq(0, 1, 0), 0);
            wr(10'd5, {27'd0, v.ien, 2'd0, v.mode});
            pin_i[5] = v.v0;
            idle(6);
            clear_all();
            wr(a_irq(0, 0, 0), 32'(v.en0) << 5);
            wr(a_irq(0, 1, 0), 32'(v.en1) << 5);
            pin_i[5] = v.v1;
            idle(6);
            rd(a_irq(0, 0, 1), d); chk($sformatf("R1/R2/R4 vec%0d N0", k), d, 32'(v.e0) << 5);
            rd(a_irq(0, 1, 1), d); chk($sformatf("R1/R2/R4 vec%0d N1", k), d, 32'(v.e1) << 5);
            chk($sformatf("R8 vec%0d irq", k), {30'd0, irq_n1_o[0], irq_n0_o[0]},
                {30'd0, v.e1, v.e0});
        end
        pin_i[5] = 1'b0;
        wr(10'd5, 0);
        wr(a_irq(0, 0, 0), 0);
        wr(a_irq(0, 1, 0), 0);
        idle(4);
        clear_all();

        // R11: config readback layout
        wr(10'd7, 32'hFFFF_FF13);
        rd(10'd7, d); chk("R11 cfg readback", d, 32'h13);
        rd(a_irq(0, 0, 2), d); chk("R11 clear reads 0", d, 0);

        // R3: input-enable change while pin high acts as an edge
        wr(10'd7, 0);
        pin_i[7] = 1'b1;
        idle(5);
        wr(a_irq(0, 0, 0), 32'h80);
        wr(10'd7, 32'h12);          // ien=1, mode rise
        idle(2);
        rd(a_irq(0, 0, 1), d); chk("R3 enable as rising", d, 32'h80);
        wr(a_irq(0, 0, 2), 32'h80);
        wr(10'd7, 32'h01);          // ien=0, mode fall
        idle(2);
        rd(a_irq(0, 0, 1), d); chk("R3 disable as falling", d, 32'h80);
        wr(a_irq(0, 0, 2), 32'h80);
        pin_i[7] = 1'b0;
        idle(5);
        wr(10'd7, 32'h13);          // ien=1 while pin low
        idle(2);
        rd(a_irq(0, 0, 1), d); chk("R3 enable while low is no edge", d, 0);
        wr(10'd7, 0);
        wr(a_irq(0, 0, 0), 0);

        // R5: pin 37 maps to bank 1 bit 5
        wr(a_irq(1, 0, 0), 32'h20);
        wr(10'd37, 32'h13);
        pin_i[37] = 1'b1;
        idle(6);
        rd(a_irq(1, 0, 1), d); chk("R5 bank1 bit5", d, 32'h20);
        rd(a_irq(0, 0, 1), d); chk("R5 bank0 untouched", d, 0);
        chk("R5 irq bank1", {31'd0, irq_n0_o[1]}, 1);
        wr(a_irq(1, 0, 0), 0);
        wr(10'd37, 0);
        pin_i[37] = 1'b0;
        idle(4);
        clear_all();

        // R6: set and clear, zero bits no effect
        wr(a_irq(0, 1, 3), 32'h100);
        rd(a_irq(0, 1, 1), d); chk("R6 set", d, 32'h100);
        wr(a_irq(0, 1, 3), 0);
        wr(a_irq(0, 1, 2), 0);
        rd(a_irq(0, 1, 1), d); chk("R6 zero writes ignored", d, 32'h100);
        wr(a_irq(0, 1, 2), 32'h100);
        rd(a_irq(0, 1, 1), d); chk("R6 clear", d, 0);

        // R7: status address is read-only
        wr(a_irq(0, 1, 1), 32'hFFFF_FFFF);
        rd(a_irq(0, 1, 1), d); chk("R7 status write ignored", d, 0);
        chk("R7 irq stays low", {31'd0, irq_n1_o[0]}, 0);

        // R8: irq needs enable; registered one cycle after enable
        wr(a_irq(0, 0, 3), 32'h8);
        idle(2);
        chk("R8 status without enable no irq", {31'd0, irq_n0_o[0]}, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a_irq(0, 0, 0); wr_data = 32'h8;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 irq not yet", {31'd0, irq_n0_o[0]}, 0);
        @(negedge clk);
        chk("R8 irq one cycle later", {31'd0, irq_n0_o[0]}, 1);
        wr(a_irq(0, 0, 2), 32'h8);
        idle(1);
        chk("R8 irq drops after clear", {31'd0, irq_n0_o[0]}, 0);
        wr(a_irq(0, 0, 0), 0);

        // R9/R12: event and clear in the same cycle
        wr(a_irq(0, 0, 0), 32'h200);
        wr(10'd9, 32'h13);
        wr(a_irq(0, 0, 3), 32'h200);
        @(negedge clk);
        pin_i[9] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a_irq(0, 0, 2); wr_data = 32'h200;
        @(negedge clk);
        wr_en = 1'b0;
        rd(a_irq(0, 0, 1), d); chk("R9 event beats clear", d, 32'h200);
        idle(3);
        wr(a_irq(0, 0, 2), 32'h200);
        rd(a_irq(0, 0, 1), d); chk("R9 control clear alone", d, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule